// File: doc/BRIEF.md
# Stereo Strip Line Buffer

This block holds a vertical strip of an odd number of image lines for a stereo matcher. It keeps three stores that always move together: left image, right image and disparity. Each store is a flat byte array of `LINES` lines, and each line holds `COLS` RGB pixels of three bytes. The middle line of the strip is the line being processed. The lines above and below it are its vertical neighbourhood.

A controller runs three phases, and only one runs at a time. A shift phase moves every line of all three stores up by one. It does this one byte per cycle, in place, and leaves the bottom line ready to be overwritten. A fill phase reads one image row from the three external RAMs into the bottom line of each store. The RAMs return data one cycle after the address. A write-back phase sends the middle line of the disparity store to the output RAM as a gray image. A separate random-read port returns one byte from each store. The byte is addressed by a signed row offset from the middle line, a column and a channel.

Top module: `stereo_strip_buf`

## Requirements
- R1: After reset, every byte of all three stores is zero. `busy`, `ramRdEn` and `ramWrEn` are low, and the row counter is zero.
- R2: The random-read port computes byte index 3·(COLS·(HALF+rdRow)+rdCol)+rdCh, where HALF=(LINES-1)/2, rdRow is signed in [-HALF, HALF] and rdCh selects R=0, G=1, B=2. It returns that byte of the left, right and disparity stores on `pixLeft`, `pixRight` and `pixDisp` one clock after the inputs are sampled.
- R3: A shift copies byte i+3·COLS to byte i for every i below 3·COLS·(LINES-1), in all three stores. It leaves the bottom line unchanged and keeps `busy` high for exactly 3·COLS·(LINES-1) cycles.
- R4: A fill holds `ramRdEn` high for 3·COLS consecutive cycles, with `ramRdAddr` = row·3·COLS + k for k = 0 upward. Each returned byte lands one cycle later at bottom-line byte k of its store. `busy` lasts 3·COLS+1 cycles. After each fill the row counter steps by one and wraps from ROWS-1 to 0.
- R5: A write-back holds `ramWrEn` high for 3·COLS consecutive cycles. `ramWrAddr` = c·3·COLS + k, where c = (row counter - 1 - HALF) mod ROWS. `ramWrData` is channel 0 of column k/3 of the disparity middle line, so all three channels of a pixel carry the same value.
- R6: Requests are accepted only while `busy` is low. If requests arrive together, shift wins over fill, and fill wins over write-back. Requests that arrive while `busy` is high have no effect.
- R7: While a shift is moving bytes, the random-read outputs hold their last value. Outside a shift they update every cycle.
- R8: `ramRdEn` and `ramWrEn` are never high in the same cycle, and neither is high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| shiftReq | input | 1 | Request a strip shift |
| fillReq | input | 1 | Request a bottom-line fill |
| wbReq | input | 1 | Request a middle-line write-back |
| busy | output | 1 | A phase is in progress |
| rdRow | input | $clog2(LINES)+1 | Signed row offset from the middle line |
| rdCol | input | $clog2(COLS) | Pixel column |
| rdCh | input | 2 | Colour channel 0..2 |
| pixLeft | output | 8 | Left store byte |
| pixRight | output | 8 | Right store byte |
| pixDisp | output | 8 | Disparity store byte |
| ramRdEn | output | 1 | Read strobe to the three source RAMs |
| ramRdAddr | output | $clog2(ROWS·3·COLS) | Shared source read address |
| ramLeftData | input | 8 | Left RAM data, one cycle after the address |
| ramRightData | input | 8 | Right RAM data, one cycle after the address |
| ramDispData | input | 8 | Disparity RAM data, one cycle after the address |
| ramWrEn | output | 1 | Output RAM write strobe |
| ramWrAddr | output | $clog2(ROWS·3·COLS) | Output RAM write address |
| ramWrData | output | 8 | Gray disparity byte |

## Verification
Two cases can fall in the same cycle. In the first, a random read and a shift overlap. The bench keeps moving the read address while bytes are being shifted, and it expects the outputs to keep the value read just before the shift began. One cycle after the shift ends, it expects the shifted contents at the new address. In the second, phase requests collide, either with each other while the block is idle or with a phase already running. The bench judges these through the RAM strobes and through the store contents read back afterwards. An unexpected read or write strobe, or a changed byte, counts as a mismatch.

// File: rtl/stereo_strip_pkg.sv
package stereo_strip_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SHIFT = 2'd1,
    PH_FILL  = 2'd2,
    PH_WB    = 2'd3
  } phase_t;

  // Strobes from the controller to the datapath.
  typedef struct packed {
    logic shiftEn;  // move one byte up by one line
    logic fillWr;   // write returned RAM byte into the bottom line
    logic wbEn;     // present one middle-line gray byte
  } stb_t;

endpackage

// File: rtl/stereo_strip_ctrl.sv
module stereo_strip_ctrl
  import stereo_strip_pkg::*;
#(
  parameter int LINES = 3,
  parameter int COLS  = 8,
  parameter int ROWS  = 5
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 shiftReq,
  input  logic                                 fillReq,
  input  logic                                 wbReq,
  output stb_t                                 strb,
  output logic [$clog2(LINES*3*COLS)-1:0]      bufIdx,
  output logic                                 busy,
  output logic                                 rdEn,
  output logic [$clog2(ROWS*3*COLS)-1:0]       rdAddr,
  output logic                                 wrEn,
  output logic [$clog2(ROWS*3*COLS)-1:0]       wrAddr
);

  localparam int LB    = 3 * COLS;
  localparam int HALF  = (LINES - 1) / 2;
  localparam int IW    = $clog2(LINES * LB);
  localparam int AW    = $clog2(ROWS * LB);
  localparam int CW    = $clog2(LINES * LB + 1);
  localparam int RW    = $clog2(ROWS);
  localparam logic [CW-1:0] SHIFT_LAST = CW'(LB * (LINES - 1) - 1);
  localparam logic [CW-1:0] FILL_LAST  = CW'(LB);
  localparam logic [CW-1:0] WB_LAST    = CW'(LB - 1);

  phase_t          phase;
  logic [CW-1:0]   cnt;
  logic [CW-1:0]   prevIdx;
  logic [RW-1:0]   fillRow;
  logic [RW-1:0]   wbRow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      prevIdx <= '0;
      fillRow <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          cnt <= '0;
          if (shiftReq)     phase <= PH_SHIFT;
          else if (fillReq) phase <= PH_FILL;
          else if (wbReq)   phase <= PH_WB;
        end
        PH_SHIFT: begin
          if (cnt == SHIFT_LAST) begin
            phase <= PH_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_FILL: begin
          prevIdx <= cnt;  // address issued now, data lands next cycle
          if (cnt == FILL_LAST) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            fillRow <= (fillRow == RW'(ROWS - 1)) ? '0 : fillRow + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_WB: begin
          if (cnt == WB_LAST) begin
            phase <= PH_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.shiftEn = (phase == PH_SHIFT);
    strb.fillWr  = (phase == PH_FILL) && (cnt != '0);
    strb.wbEn    = (phase == PH_WB);
    if (phase == PH_FILL) bufIdx = IW'(prevIdx);
    else                  bufIdx = IW'(cnt);
  end

  assign wbRow  = RW'((int'(fillRow) + ROWS - 1 - HALF) % ROWS);
  assign busy   = (phase != PH_IDLE);
  assign rdEn   = (phase == PH_FILL) && (cnt < FILL_LAST);
  assign rdAddr = AW'(int'(fillRow) * LB + int'(cnt));
  assign wrEn   = strb.wbEn;
  assign wrAddr = AW'(int'(wbRow) * LB + int'(cnt));

endmodule

// File: rtl/stereo_strip_dp.sv
module stereo_strip_dp
  import stereo_strip_pkg::*;
#(
  parameter int LINES = 3,
  parameter int COLS  = 8
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  stb_t                                 strb,
  input  logic [$clog2(LINES*3*COLS)-1:0]      bufIdx,
  input  logic [2:0][7:0]                      ramData,
  input  logic signed [$clog2(LINES):0]        rdRow,
  input  logic [$clog2(COLS)-1:0]              rdCol,
  input  logic [1:0]                           rdCh,
  output logic [2:0][7:0]                      pixOut,
  output logic [7:0]                           wbByte
);

  localparam int LB    = 3 * COLS;
  localparam int HALF  = (LINES - 1) / 2;
  localparam int BUF_B = LINES * LB;
  localparam int IW    = $clog2(BUF_B);
  localparam int BOT   = (LINES - 1) * LB;
  localparam int CBASE = HALF * LB;

  logic [IW-1:0] rdIdx;
  assign rdIdx = IW'(3 * (COLS * (HALF + int'(rdRow)) + int'(rdCol)) + int'(rdCh));

  // Stores: 0 = left image, 1 = right image, 2 = disparity.
  for (genvar g = 0; g < 3; g++) begin : gBuf
    logic [7:0] mem [BUF_B];
    logic [7:0] pixReg;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int i = 0; i < BUF_B; i++) mem[i] <= '0;
      end else if (strb.shiftEn) begin
        mem[bufIdx] <= mem[IW'(int'(bufIdx) + LB)];
      end else if (strb.fillWr) begin
        mem[IW'(BOT + int'(bufIdx))] <= ramData[g];
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN)              pixReg <= '0;
      else if (!strb.shiftEn) pixReg <= mem[rdIdx];
    end

    assign pixOut[g] = pixReg;

    if (g == 2) begin : gGray
      assign wbByte = strb.wbEn ? mem[IW'(CBASE + (int'(bufIdx) / 3) * 3)] : 8'h00;
    end
  end

endmodule

// File: rtl/stereo_strip_buf.sv
module stereo_strip_buf
  import stereo_strip_pkg::*;
#(
  parameter int LINES = 3,
  parameter int COLS  = 8,
  parameter int ROWS  = 5
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               shiftReq,
  input  logic                               fillReq,
  input  logic                               wbReq,
  output logic                               busy,
  input  logic signed [$clog2(LINES):0]      rdRow,
  input  logic [$clog2(COLS)-1:0]            rdCol,
  input  logic [1:0]                         rdCh,
  output logic [7:0]                         pixLeft,
  output logic [7:0]                         pixRight,
  output logic [7:0]                         pixDisp,
  output logic                               ramRdEn,
  output logic [$clog2(ROWS*3*COLS)-1:0]     ramRdAddr,
  input  logic [7:0]                         ramLeftData,
  input  logic [7:0]                         ramRightData,
  input  logic [7:0]                         ramDispData,
  output logic                               ramWrEn,
  output logic [$clog2(ROWS*3*COLS)-1:0]     ramWrAddr,
  output logic [7:0]                         ramWrData
);

  localparam int AW = $clog2(ROWS * 3 * COLS);
  localparam int IW = $clog2(LINES * 3 * COLS);

  stb_t            strb;
  logic [IW-1:0]   bufIdx;
  logic [2:0][7:0] pixOut;

  stereo_strip_ctrl #(.LINES(LINES), .COLS(COLS), .ROWS(ROWS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .shiftReq (shiftReq),
    .fillReq  (fillReq),
    .wbReq    (wbReq),
    .strb     (strb),
    .bufIdx   (bufIdx),
    .busy     (busy),
    .rdEn     (ramRdEn),
    .rdAddr   (ramRdAddr),
    .wrEn     (ramWrEn),
    .wrAddr   (ramWrAddr)
  );

  stereo_strip_dp #(.LINES(LINES), .COLS(COLS)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .bufIdx  (bufIdx),
    .ramData ({ramDispData, ramRightData, ramLeftData}),
    .rdRow   (rdRow),
    .rdCol   (rdCol),
    .rdCh    (rdCh),
    .pixOut  (pixOut),
    .wbByte  (ramWrData)
  );

  assign pixLeft  = pixOut[0];
  assign pixRight = pixOut[1];
  assign pixDisp  = pixOut[2];

endmodule

// File: rtl/stereo_strip_chk.sv
module stereo_strip_chk
  import stereo_strip_pkg::*;
#(
  parameter int AW = 7
) (
  input logic          clk,
  input logic          rstN,
  input stb_t          strb,
  input logic          busy,
  input logic          ramRdEn,
  input logic [AW-1:0] ramRdAddr,
  input logic          ramWrEn,
  input logic [AW-1:0] ramWrAddr,
  input logic [7:0]    ramWrData,
  input logic [7:0]    pixLeft,
  input logic [7:0]    pixRight,
  input logic [7:0]    pixDisp
);

  a_r8_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(ramRdEn && ramWrEn));

  a_r8_io_only_when_busy: assert property (@(posedge clk) disable iff (!rstN)
    (ramRdEn || ramWrEn) |-> busy);

  a_r4_rd_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    (ramRdEn && $past(ramRdEn)) |-> ramRdAddr == $past(ramRdAddr) + 1'b1);

  a_r4_write_follows_read: assert property (@(posedge clk) disable iff (!rstN)
    strb.fillWr |-> $past(ramRdEn));

  a_r5_wr_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    (ramWrEn && $past(ramWrEn)) |-> ramWrAddr == $past(ramWrAddr) + 1'b1);

  a_r5_gray_triplet: assert property (@(posedge clk) disable iff (!rstN)
    (ramWrEn && $past(ramWrEn) && (ramWrAddr % 3 != 0)) |-> ramWrData == $past(ramWrData));

  a_r7_hold_on_shift: assert property (@(posedge clk) disable iff (!rstN)
    strb.shiftEn |=> ($stable(pixLeft) && $stable(pixRight) && $stable(pixDisp)));

endmodule

bind stereo_strip_buf stereo_strip_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .strb      (strb),
  .busy      (busy),
  .ramRdEn   (ramRdEn),
  .ramRdAddr (ramRdAddr),
  .ramWrEn   (ramWrEn),
  .ramWrAddr (ramWrAddr),
  .ramWrData (ramWrData),
  .pixLeft   (pixLeft),
  .pixRight  (pixRight),
  .pixDisp   (pixDisp)
);

// File: tb/test_stereo_strip_buf.sv
`timescale 1ns/1ps
module test_stereo_strip_buf;

  localparam int LINES = 3;
  localparam int COLS  = 8;
  localparam int ROWS  = 5;
  localparam int LB    = 3 * COLS;
  localparam int HALF  = (LINES - 1) / 2;
  localparam int BUF_B = LINES * LB;
  localparam int AW    = $clog2(ROWS * LB);
  localparam int RRW   = $clog2(LINES) + 1;
  localparam int CLW   = $clog2(COLS);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic shiftReq = 1'b0, fillReq = 1'b0, wbReq = 1'b0;
  logic busy;
  logic signed [RRW-1:0] rdRow = '0;
  logic [CLW-1:0] rdCol = '0;
  logic [1:0] rdCh = '0;
  logic [7:0] pixLeft, pixRight, pixDisp;
  logic ramRdEn, ramWrEn;
  logic [AW-1:0] ramRdAddr, ramWrAddr;
  logic [7:0] ramLeftData = '0, ramRightData = '0, ramDispData = '0;
  logic [7:0] ramWrData;

  always #4 clk = ~clk;  // 125 MHz

  stereo_strip_buf #(.LINES(LINES), .COLS(COLS), .ROWS(ROWS)) i_stereo_strip_buf (
    .clk(clk), .rstN(rstN), .shiftReq(shiftReq), .fillReq(fillReq), .wbReq(wbReq),
    .busy(busy), .rdRow(rdRow), .rdCol(rdCol), .rdCh(rdCh),
    .pixLeft(pixLeft), .pixRight(pixRight), .pixDisp(pixDisp),
    .ramRdEn(ramRdEn), .ramRdAddr(ramRdAddr),
    .ramLeftData(ramLeftData), .ramRightData(ramRightData), .ramDispData(ramDispData),
    .ramWrEn(ramWrEn), .ramWrAddr(ramWrAddr), .ramWrData(ramWrData)
  );

  int nChk = 0;
  int nBad = 0;
  bit monOn = 1'b0;
  logic [7:0] mdl [3][BUF_B];
  int fillRowM = 0;
  int expRd[$];
  int expWrA[$];
  int expWrD[$];

  function automatic logic [7:0] imgByte(int g, int row, int b);
    case (g)
      0:       return 8'((row * 29 + b * 3 + 7));
      1:       return 8'((row * 17 + b * 5 + 101));
      default: return 8'((row * 41 + b * 11 + 13));
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Source RAMs: one cycle of read latency.
  always @(posedge clk) begin
    if (ramRdEn) begin
      ramLeftData  <= imgByte(0, int'(ramRdAddr) / LB, int'(ramRdAddr) % LB);
      ramRightData <= imgByte(1, int'(ramRdAddr) / LB, int'(ramRdAddr) % LB);
      ramDispData  <= imgByte(2, int'(ramRdAddr) / LB, int'(ramRdAddr) % LB);
    end
  end

  // Monitor: pops expected reads and writes.
  always @(negedge clk) begin
    if (monOn) begin
      if (ramRdEn && ramWrEn) chk("R8 rd/wr overlap", 1, 0);
      if (ramRdEn) begin
        if (expRd.size() == 0) chk("R6 unexpected read", int'(ramRdAddr), -1);
        else chk("R4 read address", int'(ramRdAddr), expRd.pop_front());
      end
      if (ramWrEn) begin
        if (expWrA.size() == 0) chk("R6 unexpected write", int'(ramWrAddr), -1);
        else begin
          chk("R5 write address", int'(ramWrAddr), expWrA.pop_front());
          chk("R5 write data", int'(ramWrData), expWrD.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChk++;
    nBad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  task automatic pulse(bit s, bit f, bit w);
    shiftReq = s; fillReq = f; wbReq = w;
    @(negedge clk);
    shiftReq = 1'b0; fillReq = 1'b0; wbReq = 1'b0;
  endtask

  task automatic waitIdle(output int n);
    n = 0;
    while (busy) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic mdlShift();
    for (int g = 0; g < 3; g++)
      for (int i = 0; i < LB * (LINES - 1); i++) mdl[g][i] = mdl[g][i + LB];
  endtask

  task automatic mdlFill();
    for (int g = 0; g < 3; g++)
      for (int b = 0; b < LB; b++) mdl[g][(LINES - 1) * LB + b] = imgByte(g, fillRowM, b);
    fillRowM = (fillRowM + 1) % ROWS;
  endtask

  task automatic pushFill();
    for (int k = 0; k < LB; k++) expRd.push_back(fillRowM * LB + k);
  endtask

  task automatic doShift();
    int n;
    pulse(1, 0, 0);
    waitIdle(n);
    mdlShift();
    chk("R3 shift cycles", n, LB * (LINES - 1));
  endtask

  task automatic doFill();
    int n;
    pushFill();
    pulse(0, 1, 0);
    waitIdle(n);
    mdlFill();
    chk("R4 fill cycles", n, LB + 1);
  endtask

  task automatic doWb();
    int n;
    int cen;
    cen = (fillRowM + ROWS - 1 - HALF) % ROWS;
    for (int k = 0; k < LB; k++) begin
      expWrA.push_back(cen * LB + k);
      expWrD.push_back(int'(mdl[2][HALF * LB + (k / 3) * 3]));
    end
    pulse(0, 0, 1);
    waitIdle(n);
    chk("R5 write-back cycles", n, LB);
    chk("R5 all writes seen", expWrA.size(), 0);
  endtask

  task automatic readChk(string req, int row, int col, int ch);
    int idx;
    rdRow = RRW'(row); rdCol = CLW'(col); rdCh = 2'(ch);
    @(negedge clk);
    idx = 3 * (COLS * (HALF + row) + col) + ch;
    chk(req, int'(pixLeft),  int'(mdl[0][idx]));
    chk(req, int'(pixRight), int'(mdl[1][idx]));
    chk(req, int'(pixDisp),  int'(mdl[2][idx]));
  endtask

  task automatic sweep(string req);
    for (int r = -HALF; r <= HALF; r++)
      for (int c = 0; c < COLS; c++)
        for (int h = 0; h < 3; h++) readChk(req, r, c, h);
  endtask

  initial begin
    int n;
    int holdBad;
    logic [7:0] hL, hR, hD;
    for (int g = 0; g < 3; g++)
      for (int i = 0; i < BUF_B; i++) mdl[g][i] = '0;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    monOn = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 rdEn after reset", int'(ramRdEn), 0);
    chk("R1 wrEn after reset", int'(ramWrEn), 0);
    sweep("R1 zero stores");

    // Load three lines: rows 0,1,2 end up top, middle, bottom.
    doFill();
    doShift();
    doFill();
    doShift();
    doFill();
    sweep("R2 random read after fills");
    readChk("R2 top corner", -HALF, 0, 0);
    readChk("R2 bottom corner", HALF, COLS - 1, 2);

    // Write-back of the middle line (row 1).
    doWb();

    // R7: outputs hold while a shift is moving bytes.
    readChk("R7 pre-shift read", -1, 2, 1);
    hL = pixLeft; hR = pixRight; hD = pixDisp;
    holdBad = 0;
    pulse(1, 0, 0);
    rdRow = RRW'(1); rdCol = CLW'(5); rdCh = 2'(0);
    n = 0;
    while (busy) begin
      if (pixLeft != hL || pixRight != hR || pixDisp != hD) holdBad++;
      n++;
      @(negedge clk);
    end
    mdlShift();
    chk("R7 held during shift", holdBad, 0);
    chk("R3 shift cycles with read", n, LB * (LINES - 1));
    readChk("R7 update after shift", 1, 5, 0);
    readChk("R3 bottom line kept", HALF, 3, 2);

    // R6: requests during a fill are ignored.
    pushFill();
    pulse(0, 1, 0);
    repeat (4) @(negedge clk);
    pulse(1, 0, 1);
    waitIdle(n);
    mdlFill();
    chk("R6 fill length unchanged", n + 5, LB + 1);
    repeat (3) begin
      chk("R6 no queued phase", int'(busy), 0);
      @(negedge clk);
    end
    sweep("R6 stores after ignored requests");

    // R6: simultaneous requests, shift wins.
    pulse(1, 1, 1);
    waitIdle(n);
    mdlShift();
    chk("R6 priority shift cycles", n, LB * (LINES - 1));
    repeat (3) begin
      chk("R6 losers dropped", int'(busy), 0);
      @(negedge clk);
    end
    sweep("R6 stores after priority");

    // R4: row counter wrap (rows 4 then 0).
    doShift();
    doFill();
    chk("R4 row counter before wrap", fillRowM, 0);
    doShift();
    doFill();
    sweep("R4 stores after wrap");
    doWb();

    repeat (2) @(negedge clk);
    chk("R4 no pending reads", expRd.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule